// File: doc/BRIEF.md
# Vectored MCU Interrupt Controller

This block decides when an 8-bit microcontroller core should take an interrupt, and which one. It has six sources. Two external pins are edge triggered, and each pin's active edge is fixed by a parameter. Two timer overflow pulses and a time-base tick each set a request flag. An A/D end-of-conversion event is signalled by the falling edge of a busy line. The request flags and the enable bits sit in two 8-bit control registers that software reads and writes whole.

When a request is accepted, the block pulses `take_irq` for one cycle and presents a vector address on `vec_addr`. The core uses the pulse to push its PC onto the return-address stack and branch to the vector. The A/D event is non-maskable: it ignores the global enable, and it is taken even while `stack_full` is high. In that case `flush_oldest` tells the core to drop its oldest return address. Maskable requests wait while the stack is full.

The sequencer has two states. In `ST_WAIT` it watches for an eligible request. Transition `WAIT->ISSUE` happens when `core_ready` is high and a request is eligible. On that edge the vector is latched, the winning flag is cleared and the global enable is cleared. `ST_ISSUE` lasts exactly one cycle and drives `take_irq`. Transition `ISSUE->WAIT` is unconditional.

Top module: `mcu_irq_ctrl`

## Requirements
- R1: After reset both control registers read 0x00, and `take_irq`, `flush_oldest` and `vec_addr` are 0.
- R2: A write with `reg_sel`=0 loads control register 0, and a write with `reg_sel`=1 loads control register 1. Bits 3 and 7 of register 1 always read 0. Register 1 bit 2 (real-time enable) and bit 6 (real-time flag) are plain storage and never cause an interrupt.
- R3: A maskable source is accepted only when all of the following hold: its enable bit is 1, its flag is 1, the global enable (register 0 bit 0) is 1, and `stack_full` is 0.
- R4: Acceptance clears the source's flag and the global enable on the same edge. In the next cycle `take_irq` is high for exactly one cycle, with the vector on `vec_addr`.
- R5: The vectors are fixed per source: external 0 is 0x04, external 1 is 0x08, timer 0 is 0x0C, timer 1 is 0x10, time base is 0x14 and A/D is 0x1C.
- R6: When several requests are eligible at once, the order is A/D first, then external 0, external 1, timer 0, timer 1 and time base.
- R7: Flags keep setting while interrupts are blocked. A pending flag is served as soon as the blocking condition goes away.
- R8: Each external pin passes through a two-flop synchronizer. An active edge sets the flag (bit 4 for pin 0, bit 5 for pin 1) three clock edges after the pin changes. The inactive edge has no effect. By default pin 0 is falling-active and pin 1 is rising-active.
- R9: A one-cycle pulse on `tmr0_ovf` sets register 0 bit 6, on `tmr1_ovf` sets register 1 bit 4, and on `tbase_tick` sets register 1 bit 5, each on the next edge. The matching enables are register 0 bit 3 and register 1 bits 0 and 1.
- R10: A falling edge of `adc_busy` while register 0 bit 7 is 1 raises a non-maskable request. That request is taken regardless of the global enable and of `stack_full`. `flush_oldest` pulses together with `take_irq` when `stack_full` was high at acceptance. With bit 7 at 0 the edge is ignored.
- R11: A software write to a control register wins over a hardware flag set in the same cycle.
- R12: No request is accepted while `core_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext0_pin | input | 1 | External request pin 0 (asynchronous) |
| ext1_pin | input | 1 | External request pin 1 (asynchronous) |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| tbase_tick | input | 1 | Time-base tick pulse |
| adc_busy | input | 1 | A/D busy; its falling edge marks end of conversion |
| stack_full | input | 1 | Return-address stack has no free level |
| core_ready | input | 1 | Core is at an instruction boundary |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_sel | input | 1 | Selects control register 0 or 1 |
| reg_wdata | input | 8 | Write data |
| ctl0_q | output | 8 | Control register 0 contents |
| ctl1_q | output | 8 | Control register 1 contents |
| take_irq | output | 1 | One-cycle take-interrupt pulse |
| vec_addr | output | VEC_W | Vector address of the taken interrupt |
| flush_oldest | output | 1 | Drop the oldest stacked return address |

## Verification
A timer or tick pulse shows in its flag one edge later. An external pin change shows in its flag three edges later, and the A/D falling edge becomes a pending request one edge later. `take_irq` rises on the edge after the cycle in which acceptance was possible, which means one edge after `core_ready`, the global enable or `stack_full` allows it. Each bench task drives its inputs just after a rising edge and samples one nanosecond after the edge whose count it has derived from these latencies. Checks before the due edge confirm that nothing has happened early.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int REG_W = 8;
    localparam int NSRC  = 6;

    // source indices, also the priority order (lowest index wins)
    localparam int SRC_NMI   = 0;
    localparam int SRC_EXT0  = 1;
    localparam int SRC_EXT1  = 2;
    localparam int SRC_TMR0  = 3;
    localparam int SRC_TMR1  = 4;
    localparam int SRC_TBASE = 5;

    // control register 0 bit positions
    localparam int C0_GEN   = 0;
    localparam int C0_EN_X0 = 1;
    localparam int C0_EN_X1 = 2;
    localparam int C0_EN_T0 = 3;
    localparam int C0_FL_X0 = 4;
    localparam int C0_FL_X1 = 5;
    localparam int C0_FL_T0 = 6;
    localparam int C0_EN_AD = 7;

    // control register 1 bit positions
    localparam int C1_EN_T1 = 0;
    localparam int C1_EN_TB = 1;
    localparam int C1_FL_T1 = 4;
    localparam int C1_FL_TB = 5;
    localparam logic [REG_W-1:0] C1_MASK = 8'h77;

    typedef enum logic [0:0] {
        ST_WAIT  = 1'b0,
        ST_ISSUE = 1'b1
    } irq_state_e;

    function automatic logic [4:0] vec_base(input int idx);
        if (idx == SRC_NMI) return 5'h1C;
        return 5'(idx * 4);
    endfunction
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int SYNC_STAGES = 2,
    parameter bit RISING      = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic pulse
);
    logic s_last;
    logic prev_q;

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign s_last = din;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[SYNC_STAGES-2+1-1:0], din} >> 0;
            end
            assign s_last = chain_q[SYNC_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= s_last;
    end

    generate
        if (RISING) begin : g_rise
            assign pulse = s_last & ~prev_q;
        end else begin : g_fall
            assign pulse = ~s_last & prev_q;
        end
    endgenerate
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int N    = NSRC,
    localparam int IW  = $clog2(N)
) (
    input  logic [N-1:0]  req_raw,
    input  logic          gen_en,
    input  logic          stack_full,
    output logic [N-1:0]  grant_oh,
    output logic [IW-1:0] grant_idx,
    output logic          grant_valid,
    output logic          grant_nmi
);
    logic [N-1:0] elig;

    assign elig[0] = req_raw[0];
    generate
        for (genvar g = 1; g < N; g++) begin : g_mask
            assign elig[g] = req_raw[g] & gen_en & ~stack_full;
        end
    endgenerate

    always_comb begin
        grant_oh  = '0;
        grant_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                grant_oh  = '0;
                grant_oh[i] = 1'b1;
                grant_idx = IW'(i);
            end
        end
    end

    assign grant_valid = |elig;
    assign grant_nmi   = elig[0];
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int IW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_ready,
    input  logic             grant_valid,
    input  logic [IW-1:0]    grant_idx,
    input  logic             grant_nmi,
    input  logic             stack_full,
    output logic             accept,
    output logic             take_irq,
    output logic [VEC_W-1:0] vec_addr,
    output logic             flush_oldest
);
    irq_state_e state_q, state_n;

    assign accept = (state_q == ST_WAIT) && core_ready && grant_valid;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_WAIT:  if (accept) state_n = ST_ISSUE;
            ST_ISSUE: state_n = ST_WAIT;
            default:  state_n = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_addr     <= '0;
            flush_oldest <= 1'b0;
        end else begin
            flush_oldest <= accept && grant_nmi && stack_full;
            if (accept) vec_addr <= VEC_W'(vec_base(int'(grant_idx)));
        end
    end

    assign take_irq = (state_q == ST_ISSUE);
endmodule

// File: rtl/mcu_irq_ctrl.sv
module mcu_irq_ctrl
    import irq_pkg::*;
#(
    parameter int VEC_W       = 8,
    parameter bit EXT0_RISING = 1'b0,
    parameter bit EXT1_RISING = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext0_pin,
    input  logic             ext1_pin,
    input  logic             tmr0_ovf,
    input  logic             tmr1_ovf,
    input  logic             tbase_tick,
    input  logic             adc_busy,
    input  logic             stack_full,
    input  logic             core_ready,
    input  logic             reg_wr_en,
    input  logic             reg_sel,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       ctl0_q,
    output logic [7:0]       ctl1_q,
    output logic             take_irq,
    output logic [VEC_W-1:0] vec_addr,
    output logic             flush_oldest
);
    localparam int IW = $clog2(NSRC);

    logic            ext0_evt, ext1_evt, adc_fall;
    logic            nmi_pend_q;
    logic [NSRC-1:0] req_raw, grant_oh;
    logic [IW-1:0]   grant_idx;
    logic            grant_valid, grant_nmi, accept;
    logic [7:0]      c0_n, c1_n;

    irq_edge_det #(.SYNC_STAGES(SYNC_STAGES), .RISING(EXT0_RISING)) u_ext0 (
        .clk(clk), .rst_n(rst_n), .din(ext0_pin), .pulse(ext0_evt));
    irq_edge_det #(.SYNC_STAGES(SYNC_STAGES), .RISING(EXT1_RISING)) u_ext1 (
        .clk(clk), .rst_n(rst_n), .din(ext1_pin), .pulse(ext1_evt));
    irq_edge_det #(.SYNC_STAGES(0), .RISING(1'b0)) u_adc (
        .clk(clk), .rst_n(rst_n), .din(adc_busy), .pulse(adc_fall));

    assign req_raw[SRC_NMI]   = nmi_pend_q;
    assign req_raw[SRC_EXT0]  = ctl0_q[C0_EN_X0] & ctl0_q[C0_FL_X0];
    assign req_raw[SRC_EXT1]  = ctl0_q[C0_EN_X1] & ctl0_q[C0_FL_X1];
    assign req_raw[SRC_TMR0]  = ctl0_q[C0_EN_T0] & ctl0_q[C0_FL_T0];
    assign req_raw[SRC_TMR1]  = ctl1_q[C1_EN_T1] & ctl1_q[C1_FL_T1];
    assign req_raw[SRC_TBASE] = ctl1_q[C1_EN_TB] & ctl1_q[C1_FL_TB];

    irq_arbiter #(.N(NSRC)) u_arb (
        .req_raw(req_raw), .gen_en(ctl0_q[C0_GEN]), .stack_full(stack_full),
        .grant_oh(grant_oh), .grant_idx(grant_idx),
        .grant_valid(grant_valid), .grant_nmi(grant_nmi));

    irq_seq_fsm #(.VEC_W(VEC_W), .IW(IW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .core_ready(core_ready),
        .grant_valid(grant_valid), .grant_idx(grant_idx), .grant_nmi(grant_nmi),
        .stack_full(stack_full), .accept(accept), .take_irq(take_irq),
        .vec_addr(vec_addr), .flush_oldest(flush_oldest));

    always_comb begin
        c0_n = ctl0_q;
        c1_n = ctl1_q;
        if (ext0_evt)   c0_n[C0_FL_X0] = 1'b1;
        if (ext1_evt)   c0_n[C0_FL_X1] = 1'b1;
        if (tmr0_ovf)   c0_n[C0_FL_T0] = 1'b1;
        if (tmr1_ovf)   c1_n[C1_FL_T1] = 1'b1;
        if (tbase_tick) c1_n[C1_FL_TB] = 1'b1;
        if (accept) begin
            c0_n[C0_GEN] = 1'b0;
            if (grant_oh[SRC_EXT0])  c0_n[C0_FL_X0] = 1'b0;
            if (grant_oh[SRC_EXT1])  c0_n[C0_FL_X1] = 1'b0;
            if (grant_oh[SRC_TMR0])  c0_n[C0_FL_T0] = 1'b0;
            if (grant_oh[SRC_TMR1])  c1_n[C1_FL_T1] = 1'b0;
            if (grant_oh[SRC_TBASE]) c1_n[C1_FL_TB] = 1'b0;
        end
        if (reg_wr_en && !reg_sel) c0_n = reg_wdata;
        if (reg_wr_en &&  reg_sel) c1_n = reg_wdata & C1_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl0_q     <= '0;
            ctl1_q     <= '0;
            nmi_pend_q <= 1'b0;
        end else begin
            ctl0_q <= c0_n;
            ctl1_q <= c1_n;
            if (adc_fall && ctl0_q[C0_EN_AD])    nmi_pend_q <= 1'b1;
            else if (accept && grant_oh[SRC_NMI]) nmi_pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             take_irq,
    input logic [VEC_W-1:0] vec_addr,
    input logic             flush_oldest,
    input logic             core_ready,
    input logic             stack_full,
    input logic             reg_wr_en,
    input logic [7:0]       ctl0_q,
    input logic [7:0]       ctl1_q
);
    localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(5'h1C);

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> !take_irq);

    assert_gen_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && !$past(reg_wr_en)) |-> !ctl0_q[0]);

    assert_mask_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && vec_addr != NMI_VEC) |-> ($past(ctl0_q[0]) && !$past(stack_full)));

    assert_ready_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> $past(core_ready));

    assert_flush_nmi_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_oldest |-> (take_irq && vec_addr == NMI_VEC));

    assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl1_q[3] == 1'b0) && (ctl1_q[7] == 1'b0));
endmodule

bind mcu_irq_ctrl irq_ctrl_checker #(.VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .take_irq(take_irq), .vec_addr(vec_addr),
    .flush_oldest(flush_oldest), .core_ready(core_ready), .stack_full(stack_full),
    .reg_wr_en(reg_wr_en), .ctl0_q(ctl0_q), .ctl1_q(ctl1_q));

// File: tb/mcu_irq_ctrl_bench.sv
`timescale 1ns/1ps
module mcu_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext0_pin = 1'b1, ext1_pin = 1'b0;
    logic       tmr0_ovf = 1'b0, tmr1_ovf = 1'b0, tbase_tick = 1'b0;
    logic       adc_busy = 1'b0, stack_full = 1'b0, core_ready = 1'b0;
    logic       reg_wr_en = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] ctl0_q, ctl1_q, vec_addr;
    logic       take_irq, flush_oldest;
    int         n_run = 0, n_fail = 0;

    mcu_irq_ctrl u_mcu_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ext0_pin(ext0_pin), .ext1_pin(ext1_pin),
        .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .tbase_tick(tbase_tick),
        .adc_busy(adc_busy), .stack_full(stack_full), .core_ready(core_ready),
        .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .ctl0_q(ctl0_q), .ctl1_q(ctl1_q), .take_irq(take_irq),
        .vec_addr(vec_addr), .flush_oldest(flush_oldest));

    always #10 clk = ~clk;

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
        step();
        reg_wr_en = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 ctl0", ctl0_q, 8'h00);
        chk("R1 ctl1", ctl1_q, 8'h00);
        chk("R1 take", {7'd0, take_irq}, 8'h00);
        chk("R1 vec", vec_addr, 8'h00);
        chk("R1 flush", {7'd0, flush_oldest}, 8'h00);
    endtask

    task automatic t_regs;
        wr(1'b1, 8'hFF);
        chk("R2 unused bits read 0", ctl1_q, 8'h77);
        wr(1'b1, 8'h44);
        wr(1'b0, 8'h01);
        core_ready = 1'b1;
        step(3);
        chk("R2 real-time bits raise nothing", {7'd0, take_irq}, 8'h00);
        chk("R2 ctl1 kept", ctl1_q, 8'h44);
        core_ready = 1'b0;
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_timer0;
        wr(1'b0, 8'h09);
        tmr0_ovf = 1'b1; step(); tmr0_ovf = 1'b0;
        chk("R9 timer0 flag", ctl0_q, 8'h49);
        step(2);
        chk("R12 held without ready", {7'd0, take_irq}, 8'h00);
        core_ready = 1'b1;
        step();
        chk("R4 take", {7'd0, take_irq}, 8'h01);
        chk("R5 timer0 vector", vec_addr, 8'h0C);
        chk("R4 flag+gen cleared", ctl0_q, 8'h08);
        step();
        chk("R4 single pulse", {7'd0, take_irq}, 8'h00);
        core_ready = 1'b0;
    endtask

    task automatic t_blocked;
        wr(1'b1, 8'h01);
        tmr1_ovf = 1'b1; step(); tmr1_ovf = 1'b0;
        core_ready = 1'b1;
        step(3);
        chk("R7 blocked no take", {7'd0, take_irq}, 8'h00);
        chk("R7 flag kept", ctl1_q, 8'h11);
        stack_full = 1'b1;
        wr(1'b0, 8'h09);
        step(2);
        chk("R3 stack full holds", {7'd0, take_irq}, 8'h00);
        stack_full = 1'b0;
        step();
        chk("R7 served later", {7'd0, take_irq}, 8'h01);
        chk("R5 timer1 vector", vec_addr, 8'h10);
        step();
        core_ready = 1'b0;
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h00);
    endtask

    task automatic t_prio;
        wr(1'b0, 8'h0F);
        wr(1'b1, 8'h03);
        tmr0_ovf = 1'b1; tmr1_ovf = 1'b1; tbase_tick = 1'b1;
        step();
        tmr0_ovf = 1'b0; tmr1_ovf = 1'b0; tbase_tick = 1'b0;
        core_ready = 1'b1;
        step();
        chk("R6 first timer0", vec_addr, 8'h0C);
        step();
        wr(1'b0, ctl0_q | 8'h01);
        chk("R6 no take during write", {7'd0, take_irq}, 8'h00);
        step();
        chk("R6 second take", {7'd0, take_irq}, 8'h01);
        chk("R6 second timer1", vec_addr, 8'h10);
        step();
        wr(1'b0, ctl0_q | 8'h01);
        step();
        chk("R5 time-base vector", vec_addr, 8'h14);
        chk("R6 third take", {7'd0, take_irq}, 8'h01);
        step();
        core_ready = 1'b0;
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h00);
    endtask

    task automatic t_ext;
        wr(1'b0, 8'h03);
        ext0_pin = 1'b0;
        step(2);
        chk("R8 not before third edge", ctl0_q, 8'h03);
        step();
        chk("R8 ext0 falling sets flag", ctl0_q, 8'h13);
        wr(1'b0, 8'h03);
        ext0_pin = 1'b1;
        step(4);
        chk("R8 ext0 rising ignored", ctl0_q, 8'h03);
        wr(1'b0, 8'h05);
        ext1_pin = 1'b1;
        step(3);
        chk("R8 ext1 rising sets flag", ctl0_q, 8'h25);
        core_ready = 1'b1;
        step();
        chk("R5 ext1 vector", vec_addr, 8'h08);
        chk("R4 ext1 take", {7'd0, take_irq}, 8'h01);
        step();
        core_ready = 1'b0;
        ext1_pin = 1'b0;
        step(4);
        chk("R8 ext1 falling ignored", ctl0_q, 8'h04);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_nmi;
        core_ready = 1'b1;
        wr(1'b0, 8'h80);
        stack_full = 1'b1;
        adc_busy = 1'b1; step();
        adc_busy = 1'b0; step();
        chk("R10 not yet", {7'd0, take_irq}, 8'h00);
        step();
        chk("R10 nmi take", {7'd0, take_irq}, 8'h01);
        chk("R10 nmi vector", vec_addr, 8'h1C);
        chk("R10 flush on full stack", {7'd0, flush_oldest}, 8'h01);
        step();
        chk("R10 flush one cycle", {7'd0, flush_oldest}, 8'h00);
        stack_full = 1'b0;
        adc_busy = 1'b1; step();
        adc_busy = 1'b0; step(2);
        chk("R10 nmi take stack free", {7'd0, take_irq}, 8'h01);
        chk("R10 no flush stack free", {7'd0, flush_oldest}, 8'h00);
        step();
        wr(1'b0, 8'h00);
        adc_busy = 1'b1; step();
        adc_busy = 1'b0; step(3);
        chk("R10 disabled edge ignored", {7'd0, take_irq}, 8'h00);
        core_ready = 1'b0;
    endtask

    task automatic t_swwin;
        reg_wr_en = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h08;
        tmr0_ovf = 1'b1;
        step();
        reg_wr_en = 1'b0; tmr0_ovf = 1'b0;
        chk("R11 write beats hw set", ctl0_q, 8'h08);
        reg_wr_en = 1'b1; reg_sel = 1'b1; reg_wdata = 8'h00;
        tmr1_ovf = 1'b1;
        step();
        reg_wr_en = 1'b0; tmr1_ovf = 1'b0;
        chk("R11 write beats hw set ctl1", ctl1_q, 8'h00);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        t_reset();
        t_regs();
        t_timer0();
        t_blocked();
        t_prio();
        t_ext();
        t_nmi();
        t_swwin();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule